// File: doc/BRIEF.md
# Register-Driven I2C Byte Transaction Engine

This block is a single-master I2C controller that software drives through four 32-bit registers. Software writes a command word that holds the 7-bit target address, an 8-bit in-target register index and a direction flag. For a write it also loads a transmit byte. It then sets a launch bit. From that one launch the block runs a complete addressed transaction on the bus. A write sends START, the target address with the write bit, the index, the data byte and STOP. A read sends START, the target address with the write bit and the index, then a repeated START, the target address with the read bit, one data byte that the master answers with NACK, and STOP.

While a transaction runs, the launch bit reads back as set, together with a read-active or write-active flag. When the transaction ends, the result appears as two sticky error flags: a setup error and a bus timeout/NACK error. Received data appears in the low byte of the receive register. Every transaction includes the index phase, so the block cannot probe a target with an address-only transfer. The block drives SCL and SDA as open-drain enables and honours clock stretching by targets, up to a limit that is set by a parameter.

Top module: `i2c_regmaster`

## Requirements
- R1: Command register (offset 0) holds target address bits 6:3 in bits 3:0, target address bits 2:0 in bits 10:8, the register index in bits 23:16 and the write flag in bit 31 (1 = write, 0 = read). Reading it back returns these fields, with all other bits zero.
- R2: A write launch puts this on the bus: one START, the address byte {addr,0}, the index, the transmit byte (offset 2, bits 7:0) and one STOP. Each byte must be acknowledged by the target.
- R3: A read launch puts this on the bus: START, {addr,0}, the index, a repeated START, {addr,1}, one byte received MSB first and answered with NACK, then STOP. The received byte appears in bits 7:0 of the receive register (offset 3).
- R4: Control register (offset 1) bit 0 (launch) reads 1 for the whole transaction. During that time bit 1 (read active) or bit 2 (write active) is also 1, whichever matches the direction. All three read 0 once the STOP is done.
- R5: While a transaction runs, writes to the command register, to the transmit register, and to the launch bit have no effect.
- R6: A NACK on any byte the master sends sets the timeout error (control bit 5). The block then sends STOP and clears the active bits, and no later byte of that transaction is sent.
- R7: If the target holds SCL low for STRETCH_MAX consecutive clocks while the master has released it, the timeout error is set and the transaction ends. A shorter stretch only delays the transaction, which then completes without error.
- R8: A launch with a nonzero size field (control bits 9:8) or a nonzero lane field (control bits 13:12) sets the setup error (control bit 4) and starts nothing on the bus.
- R9: Writing 1 to control bit 4 or bit 5 clears that flag. A launch clears both flags when the new transaction starts.
- R10: When idle, neither line is pulled low. During data bits, SDA changes only while SCL is low. With no stretching, consecutive SCL rising edges within a transaction are 4*CLK_DIV clocks apart.
- R11: After reset, all four registers read zero and both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 command, 1 control, 2 transmit, 3 receive |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench sets CLK_DIV to 4 and STRETCH_MAX to 200. With these values one bit lasts 16 clocks and a complete read takes well under a thousand clocks, so many transactions fit in one run. A 40-clock stretch by the target model lies clearly below the timeout limit, while a permanent SCL hold crosses it twice, once in the START and once in the STOP, within about 400 clocks. The small divider also lets the bench measure the exact SCL rise-to-rise spacing of 16 clocks.

// File: rtl/i2c_regmaster.sv
module i2c_regmaster #(
  parameter int CLK_DIV     = 8,
  parameter int STRETCH_MAX = 1000
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int SW = $clog2(STRETCH_MAX + 1);
  localparam logic [1:0] A_CMD = 2'd0, A_CTL = 2'd1, A_TXD = 2'd2, A_RXD = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} state_t;

  state_t        st;
  logic [1:0]    ph, xsize, xlane;
  logic [2:0]    seg;
  logic [3:0]    bitn;
  logic [DW-1:0] div;
  logic [SW-1:0] str;
  logic [7:0]    sh, rxd, txd, baddr, cur_byte, nxt_byte;
  logic [6:0]    dev;
  logic          wr, cfg_err, to_err;
  logic          busy, mtx, scl_rel, sda_rel, stretched, qtick, tmo;
  logic          unused_bits;

  function automatic logic [7:0] seg_byte(input logic [2:0] s, input logic [6:0] d,
                                          input logic [7:0] b, input logic [7:0] t,
                                          input logic w);
    case (s)
      3'd0:    return {d, 1'b0};
      3'd1:    return b;
      3'd2:    return w ? t : {d, 1'b1};
      default: return 8'hFF;
    endcase
  endfunction

  assign busy      = st != S_IDLE;
  assign mtx       = seg != 3'd3;
  assign stretched = busy && scl_rel && !scl_i;
  assign tmo       = stretched && (str == SW'(STRETCH_MAX - 1));
  assign qtick     = !stretched && (div == DW'(CLK_DIV - 1));
  assign cur_byte  = seg_byte(seg, dev, baddr, txd, wr);
  assign nxt_byte  = seg_byte(seg + 3'd1, dev, baddr, txd, wr);
  assign scl_oe    = !scl_rel;
  assign sda_oe    = !sda_rel;
  assign unused_bits = ^{bus_wdata[30:24], bus_wdata[15:14], bus_wdata[11]};

  always_comb begin
    scl_rel = 1'b1;
    sda_rel = 1'b1;
    case (st)
      S_START: begin scl_rel = (ph == 2'd1) || (ph == 2'd2); sda_rel = ph < 2'd2; end
      S_BIT:   begin scl_rel = (ph == 2'd1) || (ph == 2'd2);
                     sda_rel = (bitn < 4'd8 && mtx) ? sh[7] : 1'b1; end
      S_STOP:  begin scl_rel = ph != 2'd0; sda_rel = ph >= 2'd2; end
      default: ;
    endcase
  end

  always_comb begin
    case (bus_addr)
      A_CMD:   bus_rdata = {wr, 7'b0, baddr, 5'b0, dev[2:0], 4'b0, dev[6:3]};
      A_CTL:   bus_rdata = {18'b0, xlane, 2'b0, xsize, 2'b0, to_err, cfg_err, 1'b0,
                            busy && wr, busy && !wr, busy};
      A_TXD:   bus_rdata = {24'b0, txd};
      default: bus_rdata = {24'b0, rxd};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; seg <= '0; bitn <= '0; div <= '0; str <= '0;
      sh <= '0; rxd <= '0; txd <= '0; baddr <= '0; dev <= '0; wr <= 1'b0;
      xsize <= '0; xlane <= '0; cfg_err <= 1'b0; to_err <= 1'b0;
    end else begin
      if (bus_we && !busy) begin
        case (bus_addr)
          A_CMD: {wr, baddr, dev} <= {bus_wdata[31], bus_wdata[23:16], bus_wdata[3:0], bus_wdata[10:8]};
          A_CTL: begin xsize <= bus_wdata[9:8]; xlane <= bus_wdata[13:12]; end
          A_TXD: txd <= bus_wdata[7:0];
          default: ;
        endcase
      end
      if (bus_we && bus_addr == A_CTL) begin
        if (bus_wdata[4]) cfg_err <= 1'b0;
        if (bus_wdata[5]) to_err <= 1'b0;
        if (bus_wdata[0] && !busy) begin
          to_err <= 1'b0;
          if (bus_wdata[9:8] != 2'd0 || bus_wdata[13:12] != 2'd0) cfg_err <= 1'b1;
          else begin
            cfg_err <= 1'b0;
            st <= S_START; ph <= '0; seg <= '0; div <= '0; str <= '0;
          end
        end
      end
      if (busy) begin
        str <= stretched ? str + 1'b1 : '0;
        div <= stretched ? div : (qtick ? '0 : div + 1'b1);
        if (tmo) begin
          to_err <= 1'b1; str <= '0; div <= '0; ph <= '0;
          st <= (st == S_STOP) ? S_IDLE : S_STOP;
        end else if (qtick) begin
          ph <= ph + 1'b1;
          if (ph == 2'd2 && st == S_BIT) begin
            if (bitn < 4'd8 && !mtx) sh <= {sh[6:0], sda_i};
            if (bitn == 4'd8 && mtx && sda_i) to_err <= 1'b1;
          end
          if (ph == 2'd3) begin
            case (st)
              S_START: begin st <= S_BIT; bitn <= '0; sh <= cur_byte; end
              S_BIT:
                if (bitn != 4'd8) begin
                  bitn <= bitn + 1'b1;
                  if (mtx) sh <= {sh[6:0], 1'b0};
                end else if (to_err || (wr && seg == 3'd2) || seg == 3'd3) begin
                  st <= S_STOP;
                  if (!to_err && seg == 3'd3) rxd <= sh;
                end else begin
                  seg  <= seg + 1'b1;
                  bitn <= '0;
                  if (!wr && seg == 3'd1) st <= S_START;
                  else sh <= nxt_byte;
                end
              S_STOP: st <= S_IDLE;
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

module i2c_regmaster_chk #(
  parameter int SW          = 10,
  parameter int STRETCH_MAX = 1000
)(
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    st,
  input logic          busy,
  input logic          wr,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          cfg_err,
  input logic          to_err,
  input logic [SW-1:0] str
);
  localparam logic [1:0] ST_BIT = 2'd2, ST_STOP = 2'd3;

  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_sda_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && !scl_oe && $past(!scl_oe) && $past(st) == ST_BIT) |-> $stable(sda_oe));

  assert_stretch_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    str < SW'(STRETCH_MAX));

  assert_cfg_no_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> !busy);

  assert_launch_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!to_err && !cfg_err));

  assert_end_via_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(st) == ST_STOP);

  assert_cmd_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wr));
endmodule

bind i2c_regmaster i2c_regmaster_chk #(.SW(SW), .STRETCH_MAX(STRETCH_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .st(st), .busy(busy), .wr(wr), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .cfg_err(cfg_err), .to_err(to_err), .str(str)
);

// File: tb/i2c_regmaster_tb.sv
`timescale 1ns/1ps
module i2c_regmaster_tb_top;
  localparam int CLK_DIV = 4;
  localparam int STRETCH_MAX = 200;
  localparam logic [6:0] SLV = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        scl_oe, sda_oe;
  logic        sl_scl_low = 1'b0, sl_sda_low = 1'b0, hold_low = 1'b0;
  wire         scl_w = !(scl_oe || sl_scl_low || hold_low);
  wire         sda_w = !(sda_oe || sl_sda_low);

  i2c_regmaster #(.CLK_DIV(CLK_DIV), .STRETCH_MAX(STRETCH_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  int checks = 0, errors = 0;
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // target model
  logic [7:0] mem [256];
  logic ps = 1'b1, pd = 1'b1, act = 1'b0, tx = 1'b0, rdmode = 1'b0;
  logic stretch_en = 1'b0, nack_data = 1'b0, seen = 1'b0;
  int bc = 0, phs = 0, starts = 0, stops = 0, writes = 0, scnt = 0;
  int cyc = 0, last_rise = 0, pmin = 0, pmax = 0;
  logic [7:0] rsh = '0, ptr = '0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (scnt > 0) begin scnt--; if (scnt == 0) sl_scl_low = 1'b0; end
    if (ps && scl_w && pd && !sda_w) begin
      starts++; act = 1'b1; phs = 0; bc = 0; tx = 1'b0; rdmode = 1'b0; sl_sda_low = 1'b0;
    end else if (ps && scl_w && !pd && sda_w) begin
      stops++; act = 1'b0; tx = 1'b0; sl_sda_low = 1'b0;
    end else if (!ps && scl_w) begin
      if (seen) begin
        if (cyc - last_rise < pmin) pmin = cyc - last_rise;
        if (cyc - last_rise > pmax) pmax = cyc - last_rise;
      end
      seen = 1'b1; last_rise = cyc;
      if (act) begin
        if (bc < 8) begin if (!tx) rsh = {rsh[6:0], sda_w}; bc++; end
        else if (bc == 8) begin
          if (tx && sda_w) begin act = 1'b0; tx = 1'b0; end
          bc = 9;
        end
      end
    end else if (ps && !scl_w) begin
      if (stretch_en) begin sl_scl_low = 1'b1; scnt = 40; end
      if (act) begin
        if (bc == 8) begin
          if (tx) sl_sda_low = 1'b0;
          else if (phs == 0) begin
            if (rsh[7:1] == SLV) begin sl_sda_low = 1'b1; rdmode = rsh[0]; phs = 1; end
            else act = 1'b0;
          end else if (phs == 1) begin ptr = rsh; sl_sda_low = 1'b1; phs = 2; end
          else if (!nack_data) begin mem[ptr] = rsh; writes++; sl_sda_low = 1'b1; end
        end else if (bc == 9) begin
          sl_sda_low = 1'b0; bc = 0;
          if (rdmode) begin tx = 1'b1; sl_sda_low = !mem[ptr][7]; end
        end else if (tx) sl_sda_low = !mem[ptr][7-bc];
      end
    end
    ps = scl_w; pd = sda_w;
  end

  // scoreboard
  typedef struct { string tag; logic [31:0] val; } item_t;
  item_t exp_q[$];
  logic [31:0] obs_q[$];

  task automatic expect_item(input string tag, input logic [31:0] v);
    item_t it; it.tag = tag; it.val = v; exp_q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (obs_q.size() > 0) begin
      item_t e;
      logic [31:0] o;
      o = obs_q.pop_front();
      if (exp_q.size() == 0) check("scoreboard underflow", o, 32'hx);
      else begin e = exp_q.pop_front(); check(e.tag, o, e.val); end
    end
  end

  // driver
  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [31:0] cmd(input logic w, input logic [6:0] dv, input logic [7:0] ba);
    return {w, 7'b0, ba, 5'b0, dv[2:0], 4'b0, dv[6:3]};
  endfunction

  task automatic wait_idle(output logic [31:0] c2);
    c2 = '1;
    for (int i = 0; i < 5000; i++) begin
      rd_reg(2'd1, c2);
      if (c2[2:0] == 3'b000) break;
    end
  endtask

  task automatic txn(input logic w, input logic [6:0] dv, input logic [7:0] ba,
                     input logic [7:0] d, output logic [31:0] snap,
                     output logic [31:0] c2, output logic [31:0] rx);
    starts = 0; stops = 0; seen = 1'b0; pmin = 1000000; pmax = 0;
    if (w) wr_reg(2'd2, {24'b0, d});
    wr_reg(2'd0, cmd(w, dv, ba));
    wr_reg(2'd1, 32'h1);
    rd_reg(2'd1, snap);
    wait_idle(c2);
    rd_reg(2'd3, rx);
  endtask

  logic [31:0] snap, c2, rx, v;
  int wbase;

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // R11 reset state
    for (int a = 0; a < 4; a++) begin rd_reg(2'(a), v); check("R11 register reset", v, 0); end
    check("R11 lines released", {scl_oe, sda_oe}, 0);

    // R1 field layout
    wr_reg(2'd0, 32'hFFFF_FFFF); rd_reg(2'd0, v);
    check("R1 command readback", v, 32'h80FF_070F);

    // R2 write, R4 status, R10 timing
    expect_item("R4 write active", 32'h5); expect_item("R2 status", 32'h0);
    txn(1'b1, SLV, 8'h10, 8'hC3, snap, c2, rx);
    obs_q.push_back(snap); obs_q.push_back(c2);
    check("R2 target byte", mem[8'h10], 8'hC3);
    check("R2 one start", starts, 1); check("R2 one stop", stops, 1);
    check("R10 min SCL period", pmin, 4 * CLK_DIV);
    check("R10 max SCL period", pmax, 4 * CLK_DIV);
    check("R10 idle release", {scl_oe, sda_oe}, 0);

    // R3 reads
    expect_item("R4 read active", 32'h3); expect_item("R3 status", 32'h0);
    expect_item("R3 rx byte", 32'hC3);
    txn(1'b0, SLV, 8'h10, 8'h00, snap, c2, rx);
    obs_q.push_back(snap); obs_q.push_back(c2); obs_q.push_back(rx);
    check("R3 repeated start", starts, 2); check("R3 one stop", stops, 1);
    expect_item("R3 rx preset", 32'h4B);
    txn(1'b0, SLV, 8'h77, 8'h00, snap, c2, rx);
    obs_q.push_back(rx);

    // R5 writes while busy ignored
    wbase = writes; starts = 0;
    wr_reg(2'd2, 32'h11); wr_reg(2'd0, cmd(1'b1, SLV, 8'h20)); wr_reg(2'd1, 32'h1);
    wr_reg(2'd0, cmd(1'b0, SLV, 8'h99)); wr_reg(2'd2, 32'hEE); wr_reg(2'd1, 32'h1);
    wait_idle(c2);
    repeat (40) @(posedge clk);
    rd_reg(2'd0, v);
    check("R5 command held", v, cmd(1'b1, SLV, 8'h20));
    rd_reg(2'd2, v); check("R5 transmit held", v, 32'h11);
    check("R5 data sent", mem[8'h20], 8'h11);
    check("R5 other index untouched", mem[8'h99], 8'hA5);
    check("R5 single write", writes - wbase, 1);
    check("R5 single start", starts, 1);

    // R6 address NACK, R9 W1C
    wbase = writes;
    expect_item("R6 addr nack status", 32'h20);
    txn(1'b1, 7'h11, 8'h30, 8'h55, snap, c2, rx);
    obs_q.push_back(c2);
    check("R6 stop after nack", stops, 1);
    check("R6 no write", writes - wbase, 0);
    check("R6 lines released", {scl_oe, sda_oe}, 0);
    wr_reg(2'd1, 32'h20); rd_reg(2'd1, v);
    check("R9 w1c timeout flag", v, 32'h0);

    // R6 data NACK
    nack_data = 1'b1;
    expect_item("R6 data nack status", 32'h20);
    txn(1'b1, SLV, 8'h30, 8'h55, snap, c2, rx);
    obs_q.push_back(c2);
    nack_data = 1'b0;
    check("R6 data not stored", mem[8'h30], 8'h0C);

    // R9 launch clears timeout flag
    expect_item("R9 launch clears to", 32'h3); expect_item("R9 end status", 32'h0);
    txn(1'b0, SLV, 8'h10, 8'h00, snap, c2, rx);
    obs_q.push_back(snap); obs_q.push_back(c2);

    // R8 setup errors
    starts = 0;
    wr_reg(2'd1, 32'h101); repeat (60) @(posedge clk); rd_reg(2'd1, v);
    check("R8 size error", v, 32'h110);
    check("R8 no bus activity", starts, 0);
    wr_reg(2'd1, 32'h10); rd_reg(2'd1, v);
    check("R9 w1c setup flag", v, 32'h0);
    wr_reg(2'd1, 32'h1001); repeat (60) @(posedge clk); rd_reg(2'd1, v);
    check("R8 lane error", v, 32'h1010);
    check("R8 no bus activity lane", starts, 0);
    expect_item("R9 launch clears cfg", 32'h3);
    txn(1'b0, SLV, 8'h10, 8'h00, snap, c2, rx);
    obs_q.push_back(snap);

    // R7 short stretch and timeout
    stretch_en = 1'b1;
    expect_item("R7 stretched status", 32'h0);
    txn(1'b1, SLV, 8'h40, 8'h9D, snap, c2, rx);
    obs_q.push_back(c2);
    stretch_en = 1'b0;
    repeat (50) @(posedge clk);
    check("R7 stretched data", mem[8'h40], 8'h9D);
    check("R7 period lengthened", 32'(pmax > 4 * CLK_DIV), 1);
    hold_low = 1'b1;
    expect_item("R7 timeout status", 32'h20);
    txn(1'b1, SLV, 8'h41, 8'h12, snap, c2, rx);
    obs_q.push_back(c2);
    hold_low = 1'b0;
    check("R7 no data on timeout", mem[8'h41], 8'h7D);
    check("R10 released after timeout", {scl_oe, sda_oe}, 0);

    repeat (10) @(posedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule